// File: doc/BRIEF.md
# Condition code register with interrupt gating

This block keeps the processor status byte of a small 8-bit core: a half-carry flag, the interrupt mask, and the negative, zero and carry flags, with the three top bits tied high. The ALU reports its result byte and its carry outputs, along with strobes that say which flags the current operation may touch. The decoder drives separate strobes for setting and clearing the mask, for entering an interrupt, for returning from one, and for popping a saved status byte. The full byte is always visible on `ccr_out`, so the stack logic can push it whenever it needs to.

The block also holds a small front end for pending interrupts. Each maskable source leaves a pending bit that stays set until that source is acknowledged. The front end raises `take_irq`, together with the number of the lowest pending source, only while the mask is clear. A software trap request is latched on its own, it is offered through `take_trap` whatever the mask is doing, and it takes precedence over maskable requests. Reset leaves the mask set, so no maskable request can be taken until software clears it.

Top module: `ccr_unit`

## Requirements
- R1: Bits 7 to 5 of `ccr_out` always read 1. Writes to those bits from `pop_val` or `iret_val` are ignored.
- R2: After reset `ccr_out` is 8'hE8, which means I (bit 3) is 1 and H, N, Z and C are 0. After reset no request is pending, and `take_irq` and `take_trap` are 0.
- R3: H (bit 4) takes `alu_hc` when `alu_we` and `alu_add` are both 1. In every other case where neither a pop nor a return loads the register, H keeps its value.
- R4: When `alu_we` and `upd_nz` are both 1, N (bit 2) takes `alu_res[7]` and Z (bit 1) becomes 1 exactly when `alu_res` is 0. When `alu_we` and `upd_c` are both 1, C (bit 0) takes `alu_cout`.
- R5: I (bit 3) is set by `int_enter` or `sim_stb` and cleared by `rim_stb`. If a set strobe and `rim_stb` arrive in the same cycle, the set wins.
- R6: `iret_stb` loads bits 4 to 0 from `iret_val` on the next edge. It overrides every other update in that cycle.
- R7: `pop_stb` loads bits 4 to 0 from `pop_val` on the next edge. It overrides every update except `iret_stb`.
- R8: `trap_req` latches a trap that stays pending until `trap_ack`. A request in the same cycle as the acknowledge wins. `take_trap` is 1 while the trap is pending, whatever the value of I.
- R9: `irq_req[k]` sets pending bit k whatever the value of I. `irq_ack[k]` clears it, and a request in the same cycle as its acknowledge wins.
- R10: `take_irq` is 1 exactly when some maskable request is pending, I is 0 and no trap is pending. A request held while the mask is set is taken in the cycle after I clears.
- R11: `take_vec` gives the lowest-numbered pending source while `take_irq` is 1, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| alu_we | input | 1 | An ALU operation completes this cycle |
| alu_add | input | 1 | The operation is add-type and updates H |
| upd_nz | input | 1 | The operation updates N and Z |
| upd_c | input | 1 | The operation updates C |
| alu_res | input | 8 | ALU result byte |
| alu_cout | input | 1 | ALU carry or borrow out |
| alu_hc | input | 1 | Carry from bit 3 into bit 4 |
| sim_stb | input | 1 | Set the interrupt mask |
| rim_stb | input | 1 | Clear the interrupt mask |
| int_enter | input | 1 | Interrupt entry, sets the mask |
| iret_stb | input | 1 | Interrupt return, restore the register |
| iret_val | input | 8 | Saved status byte restored on return |
| pop_stb | input | 1 | Load the register from the pop port |
| pop_val | input | 8 | Popped status byte |
| irq_req | input | NSRC | Maskable interrupt requests |
| irq_ack | input | NSRC | Acknowledges, one bit per source |
| trap_req | input | 1 | Software trap request |
| trap_ack | input | 1 | Software trap acknowledge |
| ccr_out | output | 8 | Full status byte, used for push |
| take_irq | output | 1 | A maskable interrupt should be taken |
| take_vec | output | VW | Index of the source being offered |
| take_trap | output | 1 | The software trap should be taken |

## Verification
The assertions check on every cycle that the top bits stay high, that the two whole-register loads land with their priority intact, and that H holds outside add-type operations. They also check that the set strobes raise the mask, that no maskable interrupt is offered while the mask is set or while a trap is pending, and that a trap request is always offered on the next cycle. Only the bench scenarios can show that a request stays pending through a masked period and is offered in the cycle after the mask clears. The same holds for lowest-index selection among several pending sources, for the exact N, Z and C values computed from mixed ALU results, and for the request-over-acknowledge rule.

// File: rtl/ccr_unit.sv
module ccr_unit #(
  parameter int NSRC = 4,
  localparam int VW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            alu_we,
  input  logic            alu_add,
  input  logic            upd_nz,
  input  logic            upd_c,
  input  logic [7:0]      alu_res,
  input  logic            alu_cout,
  input  logic            alu_hc,
  input  logic            sim_stb,
  input  logic            rim_stb,
  input  logic            int_enter,
  input  logic            iret_stb,
  input  logic [7:0]      iret_val,
  input  logic            pop_stb,
  input  logic [7:0]      pop_val,
  input  logic [NSRC-1:0] irq_req,
  input  logic [NSRC-1:0] irq_ack,
  input  logic            trap_req,
  input  logic            trap_ack,
  output logic [7:0]      ccr_out,
  output logic            take_irq,
  output logic [VW-1:0]   take_vec,
  output logic            take_trap
);

  logic [4:0]      cc;
  logic [NSRC-1:0] pend;
  logic            trap_p;
  logic [VW-1:0]   low_idx;
  logic            unused_hi;

  assign unused_hi = ^{iret_val[7:5], pop_val[7:5]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cc <= 5'b01000;
    end else if (iret_stb) begin
      cc <= iret_val[4:0];
    end else if (pop_stb) begin
      cc <= pop_val[4:0];
    end else begin
      if (alu_we && alu_add) cc[4] <= alu_hc;
      if (alu_we && upd_nz) begin
        cc[2] <= alu_res[7];
        cc[1] <= (alu_res == 8'h00);
      end
      if (alu_we && upd_c) cc[0] <= alu_cout;
      if (int_enter || sim_stb) cc[3] <= 1'b1;
      else if (rim_stb)         cc[3] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend   <= '0;
      trap_p <= 1'b0;
    end else begin
      pend   <= (pend & ~irq_ack) | irq_req;
      trap_p <= (trap_p & ~trap_ack) | trap_req;
    end
  end

  always_comb begin
    low_idx = '0;
    for (int k = NSRC - 1; k >= 0; k--)
      if (pend[k]) low_idx = VW'(k);
  end

  assign ccr_out   = {3'b111, cc};
  assign take_trap = trap_p;
  assign take_irq  = (|pend) && !cc[3] && !trap_p;
  assign take_vec  = take_irq ? low_idx : '0;

endmodule

// File: rtl/ccr_unit_chk.sv
module ccr_unit_chk #(
  parameter int NSRC = 4,
  localparam int VW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          alu_we,
  input logic          alu_add,
  input logic          sim_stb,
  input logic          int_enter,
  input logic          iret_stb,
  input logic [7:0]    iret_val,
  input logic          pop_stb,
  input logic [7:0]    pop_val,
  input logic          trap_req,
  input logic [7:0]    ccr_out,
  input logic          take_irq,
  input logic          take_trap
);

  a_r1_upper_ones: assert property (@(posedge clk) disable iff (!rst_n)
    ccr_out[7:5] == 3'b111);

  a_r3_h_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!iret_stb && !pop_stb && !(alu_we && alu_add)) |=> $stable(ccr_out[4]));

  a_r5_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
    (!iret_stb && !pop_stb && (sim_stb || int_enter)) |=> ccr_out[3]);

  a_r6_iret_load: assert property (@(posedge clk) disable iff (!rst_n)
    iret_stb |=> ccr_out[4:0] == $past(iret_val[4:0]));

  a_r7_pop_load: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_stb && !iret_stb) |=> ccr_out[4:0] == $past(pop_val[4:0]));

  a_r8_trap_taken: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |=> take_trap);

  a_r10_masked: assert property (@(posedge clk) disable iff (!rst_n)
    ccr_out[3] |-> !take_irq);

  a_r10_trap_first: assert property (@(posedge clk) disable iff (!rst_n)
    take_trap |-> !take_irq);

endmodule

bind ccr_unit ccr_unit_chk #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .alu_we(alu_we), .alu_add(alu_add),
  .sim_stb(sim_stb), .int_enter(int_enter), .iret_stb(iret_stb),
  .iret_val(iret_val), .pop_stb(pop_stb), .pop_val(pop_val),
  .trap_req(trap_req), .ccr_out(ccr_out), .take_irq(take_irq),
  .take_trap(take_trap)
);

// File: tb/sim_ccr_unit.sv
`timescale 1ns/1ps
module sim_ccr_unit;
  localparam int NSRC = 4;
  localparam int VW = 2;

  logic clk = 0, rst_n = 0;
  logic alu_we, alu_add, upd_nz, upd_c, alu_cout, alu_hc;
  logic [7:0] alu_res, iret_val, pop_val;
  logic sim_stb, rim_stb, int_enter, iret_stb, pop_stb, trap_req, trap_ack;
  logic [NSRC-1:0] irq_req, irq_ack;
  logic [7:0] ccr_out;
  logic take_irq, take_trap;
  logic [VW-1:0] take_vec;

  int nchk = 0, nfail = 0;
  bit done = 0;
  logic [4:0] m_cc;
  logic [NSRC-1:0] m_pend;
  logic m_trap;

  always #2 clk = ~clk;

  ccr_unit #(.NSRC(NSRC)) u0 (.*);

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic idle();
    alu_we = 0; alu_add = 0; upd_nz = 0; upd_c = 0; alu_cout = 0; alu_hc = 0;
    alu_res = 0; iret_val = 0; pop_val = 0; sim_stb = 0; rim_stb = 0;
    int_enter = 0; iret_stb = 0; pop_stb = 0; trap_req = 0; trap_ack = 0;
    irq_req = 0; irq_ack = 0;
  endtask

  function automatic logic [VW-1:0] lowest(logic [NSRC-1:0] p);
    for (int k = 0; k < NSRC; k++) if (p[k]) return VW'(k);
    return '0;
  endfunction

  function automatic logic exp_take();
    return (|m_pend) && !m_cc[3] && !m_trap;
  endfunction

  task automatic model();
    if (iret_stb) m_cc = iret_val[4:0];
    else if (pop_stb) m_cc = pop_val[4:0];
    else begin
      if (alu_we && alu_add) m_cc[4] = alu_hc;
      if (alu_we && upd_nz) begin m_cc[2] = alu_res[7]; m_cc[1] = (alu_res == 0); end
      if (alu_we && upd_c) m_cc[0] = alu_cout;
      if (int_enter || sim_stb) m_cc[3] = 1;
      else if (rim_stb) m_cc[3] = 0;
    end
    m_pend = (m_pend & ~irq_ack) | irq_req;
    m_trap = (m_trap & ~trap_ack) | trap_req;
  endtask

  task automatic step();
    @(posedge clk);
    model();
    #1;
    chk("R1 upper bits", ccr_out[7:5], 3'b111);
    chk("R3 H", ccr_out[4], m_cc[4]);
    chk("R5 I", ccr_out[3], m_cc[3]);
    chk("R4 NZC", ccr_out[2:0], m_cc[2:0]);
    chk("R8 take_trap", take_trap, m_trap);
    chk("R10 take_irq", take_irq, exp_take());
    chk("R11 take_vec", take_vec, exp_take() ? lowest(m_pend) : '0);
    @(negedge clk);
    idle();
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240517));
    idle();
    m_cc = 5'b01000; m_pend = 0; m_trap = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R2 reset ccr", ccr_out, 8'hE8);
    chk("R2 reset take_irq", take_irq, 0);
    chk("R2 reset take_trap", take_trap, 0);
    rst_n = 1;
    @(negedge clk);

    irq_req = 4'b0100; step();
    chk("R9 masked request held, not taken", take_irq, 0);
    rim_stb = 1; step();
    chk("R10 taken after mask clears", take_irq, 1);
    chk("R11 vector of held request", take_vec, 2);
    irq_req = 4'b1010; step();
    chk("R11 lowest pending wins", take_vec, 1);
    irq_ack = 4'b0010; irq_req = 4'b0010; step();
    chk("R9 request beats ack", take_vec, 1);
    irq_ack = 4'b1110; step();
    chk("R9 acks clear pending", take_irq, 0);

    pop_val = 8'h00; pop_stb = 1; sim_stb = 1; step();
    chk("R7 pop load, R1 top bits", ccr_out, 8'hE0);
    iret_val = 8'h1F; iret_stb = 1; pop_stb = 1; pop_val = 8'h00; rim_stb = 1; step();
    chk("R6 iret overrides", ccr_out, 8'hFF);
    trap_req = 1; step();
    chk("R8 trap ignores mask", take_trap, 1);
    trap_ack = 1; trap_req = 1; step();
    chk("R8 trap request beats ack", take_trap, 1);
    trap_ack = 1; step();
    chk("R8 trap ack", take_trap, 0);
    alu_we = 1; upd_nz = 1; upd_c = 1; alu_hc = 0; alu_res = 8'h00; alu_cout = 0; step();
    chk("R3 H held on non-add", ccr_out[4], 1);
    chk("R4 Z set, N C clear", ccr_out[2:0], 3'b010);
    alu_we = 1; alu_add = 1; upd_nz = 1; alu_hc = 0; alu_res = 8'h80; step();
    chk("R3 H cleared by add", ccr_out[4], 0);
    chk("R4 N set", ccr_out[2:1], 2'b10);
    sim_stb = 1; rim_stb = 1; step();
    chk("R5 set wins over clear", ccr_out[3], 1);

    for (int n = 0; n < 3000; n++) begin
      alu_we = $urandom_range(0, 1); alu_add = $urandom_range(0, 1);
      upd_nz = $urandom_range(0, 1); upd_c = $urandom_range(0, 1);
      alu_res = ($urandom_range(0, 3) == 0) ? 8'h00 : 8'($urandom);
      alu_cout = $urandom_range(0, 1); alu_hc = $urandom_range(0, 1);
      sim_stb = ($urandom_range(0, 9) == 0); rim_stb = ($urandom_range(0, 4) == 0);
      int_enter = take_irq && ($urandom_range(0, 1) == 1);
      iret_stb = ($urandom_range(0, 15) == 0); iret_val = 8'($urandom);
      pop_stb = ($urandom_range(0, 15) == 0); pop_val = 8'($urandom);
      irq_req = ($urandom_range(0, 2) == 0) ? NSRC'($urandom) : '0;
      irq_ack = ($urandom_range(0, 2) == 0) ? NSRC'($urandom) : '0;
      trap_req = ($urandom_range(0, 19) == 0); trap_ack = ($urandom_range(0, 3) == 0);
      step();
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule